// File: doc/BRIEF.md
# Periodic HDLC Message Sender for the E3 GC Overhead Byte

This block places a stored link-layer message into the GC overhead byte of an outbound E3 stream, one octet per E3 frame. Software loads the message octets into an internal buffer, sets the message length and starts the sender with one register write. The block then frames the message with an opening and a closing HDLC flag (0x7E). After the frame has finished, it waits a fixed number of E3 frames and sends the message again. It keeps doing this until software stops it. In the gaps between messages the GC byte carries flag octets.

The framer gives the block one strobe per outbound E3 frame, at the moment its GC byte is due. On each strobe the block registers the octet for that slot on `gc_byte`. A routing control picks the source of the GC byte. When the sender owns the byte it supplies the HDLC stream. Otherwise the GC byte is a static value that software programs in a register. A control/status register reports whether a message is in flight and holds a completion flag that clears when the register is read. The completion flag can raise an interrupt.

Zero-bit insertion and the frame check sequence are not added here. The buffer must already hold the message in its final form, one octet per GC slot. Strobes must be at least three clock cycles apart. A length of 0 is treated as 1.

Top module: `gc_hdlc_repeater`

## Requirements
- R1: After reset, `gc_byte` and `irq` are 0, and both the control/status register (address 0x34) and the GC register (address 0x35) read 0x00.
- R2: The GC register at 0x35 is readable and writable. The GC slot carries its value when the sender is stopped and no frame is in flight, or when the route bit (bit 4 of 0x34) is 1. `gc_byte` changes only in the cycle after a strobe.
- R3: Writing 1 to the run bit (bit 3 of 0x34) while it is 0 starts a send at the next slot. That slot carries an opening 0x7E, the next `msg_len` slots carry buffer octets 0 to `msg_len`-1 in order, and the slot after them carries a closing 0x7E.
- R4: The slot after the closing flag is the completion slot. Every slot between messages carries 0x7E. The next opening flag falls on the PERIOD_FRAMES-th slot after the completion slot.
- R5: The busy bit (bit 2 of 0x34, read-only) is 1 from the slot that carries the opening flag through the slot that carries the closing flag. It is 0 from the completion slot on.
- R6: The done bit (bit 0 of 0x34) is set at the completion slot. A read of 0x34 returns the value the bit held before the read and then clears it. When a completion and a read fall in the same cycle, the bit is left set.
- R7: The interrupt enable (bit 1 of 0x34) is readable and writable. `irq` equals the done bit ANDed with the interrupt enable.
- R8: Writing 0 to the run bit lets a frame that is in flight finish, including its completion. After that no further message is sent, and the slots carry the GC register value.
- R9: While the sender owns the GC byte (route bit 0, and either running or a frame in flight), the GC register value never appears in the slot. Setting the route bit at that time puts the GC register value in the next slot.
- R10: Octets written through the buffer port between repeats appear in the next repeat of the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read applies) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, registered on the cycle after `reg_rd` |
| msg_wr | input | 1 | Message buffer write enable |
| msg_waddr | input | AW | Message buffer write address |
| msg_wdata | input | 8 | Message buffer write data |
| msg_len | input | LW | Number of message octets (1 to DEPTH) |
| gc_strobe | input | 1 | One pulse per outbound E3 frame, at its GC byte slot |
| gc_byte | output | 8 | Registered GC byte for the current frame |
| irq | output | 1 | Completion interrupt |

## Verification
The main sequence is run with a one-octet message, a message that fills the buffer, and two medium lengths, each with its own octet pattern. The one-octet and full-buffer cases show whether the index and the last-octet detection are wrong at either end. Each case runs for two full periods, and the buffer is rewritten in between. This shows whether the repeat timer restarts from the completion slot, and whether the repeat reads fresh buffer contents rather than stale ones. The GC register holds a value that differs from every flag and data octet, so a routing error shows up at once. Further directed tests cover a stop in mid-frame, a change of route in mid-frame, and a read of the status register in the same cycle as a completion.

// File: rtl/gchdlc_pkg.sv
package gchdlc_pkg;

  localparam logic [7:0] HDLC_FLAG = 8'h7E;

  // control/status bit positions
  localparam int CS_DONE  = 0;
  localparam int CS_IE    = 1;
  localparam int CS_BUSY  = 2;
  localparam int CS_RUN   = 3;
  localparam int CS_ROUTE = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,   // flag fill, waiting for a trigger
    SQ_BODY,   // message octets on the slot
    SQ_CLOSE,  // closing flag goes out next
    SQ_FIN     // closing flag on the slot, completion next
  } seq_state_t;

endpackage

// File: rtl/gchdlc_msg_ram.sv
module gchdlc_msg_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/gchdlc_slot_timer.sv
module gchdlc_slot_timer #(
  parameter int PERIOD_FRAMES = 8000,
  localparam int CW = $clog2(PERIOD_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic busy,
  input  logic done,
  output logic hit
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strobe) begin
      if (done) begin
        cnt <= CW'(1);
      end else if (!busy && cnt != CW'(PERIOD_FRAMES)) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign hit = (cnt == CW'(PERIOD_FRAMES));

endmodule

// File: rtl/gchdlc_frame_seq.sv
module gchdlc_frame_seq
  import gchdlc_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          trig,
  input  logic [LW-1:0] msg_len,
  input  logic [7:0]    ram_q,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          launch,
  output logic          done,
  output logic [7:0]    octet
);

  seq_state_t    st;
  logic [AW-1:0] idx;
  logic          last;

  assign last    = (LW'(idx) + LW'(1)) >= msg_len;
  assign launch  = strobe && (st == SQ_IDLE) && trig;
  assign done    = strobe && (st == SQ_FIN);
  assign octet   = (st == SQ_BODY) ? ram_q : HDLC_FLAG;
  assign rd_addr = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      idx  <= '0;
      busy <= 1'b0;
    end else if (strobe) begin
      case (st)
        SQ_IDLE: begin
          if (trig) begin
            st   <= SQ_BODY;
            busy <= 1'b1;
            idx  <= '0;
          end
        end
        SQ_BODY: begin
          if (last) begin
            st  <= SQ_CLOSE;
            idx <= '0;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        SQ_CLOSE: st <= SQ_FIN;
        SQ_FIN: begin
          st   <= SQ_IDLE;
          busy <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gchdlc_csr.sv
module gchdlc_csr
  import gchdlc_pkg::*;
#(
  parameter logic [7:0] CSR_ADDR = 8'h34,
  parameter logic [7:0] GC_ADDR  = 8'h35
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       busy,
  input  logic       launch,
  input  logic       done,
  output logic       run,
  output logic       route,
  output logic       pend,
  output logic       stat,
  output logic       ie,
  output logic [7:0] gc_reg,
  output logic       irq
);

  logic wr_cs, rd_cs, wr_gc, rd_gc;
  logic stat_n, ie_n;

  assign wr_cs = wr && (addr == CSR_ADDR);
  assign rd_cs = rd && (addr == CSR_ADDR);
  assign wr_gc = wr && (addr == GC_ADDR);
  assign rd_gc = rd && (addr == GC_ADDR);

  always_comb begin
    stat_n = stat;
    if (rd_cs) stat_n = 1'b0;
    if (done)  stat_n = 1'b1;   // completion beats the read
    ie_n = wr_cs ? wdata[CS_IE] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      route  <= 1'b0;
      pend   <= 1'b0;
      stat   <= 1'b0;
      ie     <= 1'b0;
      gc_reg <= 8'h00;
      irq    <= 1'b0;
      rdata  <= 8'h00;
    end else begin
      stat <= stat_n;
      ie   <= ie_n;
      irq  <= stat_n & ie_n;
      if (wr_cs) begin
        run   <= wdata[CS_RUN];
        route <= wdata[CS_ROUTE];
        pend  <= wdata[CS_RUN] & ((pend & ~launch) | ~run);
      end else if (launch) begin
        pend <= 1'b0;
      end
      if (wr_gc) begin
        gc_reg <= wdata;
      end
      if (rd_cs) begin
        rdata <= {3'b000, route, run, busy, ie, stat};
      end else if (rd_gc) begin
        rdata <= gc_reg;
      end else if (rd) begin
        rdata <= 8'h00;
      end
    end
  end

endmodule

// File: rtl/gc_hdlc_repeater.sv
module gc_hdlc_repeater #(
  parameter int         DEPTH         = 64,
  parameter int         PERIOD_FRAMES = 8000,
  parameter logic [7:0] CSR_ADDR      = 8'h34,
  parameter logic [7:0] GC_ADDR       = 8'h35,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          msg_wr,
  input  logic [AW-1:0] msg_waddr,
  input  logic [7:0]    msg_wdata,
  input  logic [LW-1:0] msg_len,
  input  logic          gc_strobe,
  output logic [7:0]    gc_byte,
  output logic          irq
);

  logic [AW-1:0] rd_addr;
  logic [7:0]    ram_q, octet, gc_reg;
  logic          seq_busy, launch, done, hit, trig;
  logic          run, route, pend, csr_stat, csr_ie;
  logic          hdlc_owns;

  gchdlc_msg_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (msg_wr),
    .waddr (msg_waddr),
    .wdata (msg_wdata),
    .raddr (rd_addr),
    .rdata (ram_q)
  );

  gchdlc_slot_timer #(.PERIOD_FRAMES(PERIOD_FRAMES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .strobe (gc_strobe),
    .busy   (seq_busy),
    .done   (done),
    .hit    (hit)
  );

  assign trig = run & (pend | hit);

  gchdlc_frame_seq #(.DEPTH(DEPTH)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .strobe  (gc_strobe),
    .trig    (trig),
    .msg_len (msg_len),
    .ram_q   (ram_q),
    .rd_addr (rd_addr),
    .busy    (seq_busy),
    .launch  (launch),
    .done    (done),
    .octet   (octet)
  );

  gchdlc_csr #(.CSR_ADDR(CSR_ADDR), .GC_ADDR(GC_ADDR)) u_csr (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .busy   (seq_busy),
    .launch (launch),
    .done   (done),
    .run    (run),
    .route  (route),
    .pend   (pend),
    .stat   (csr_stat),
    .ie     (csr_ie),
    .gc_reg (gc_reg),
    .irq    (irq)
  );

  assign hdlc_owns = (run | seq_busy) & ~route;

  always_ff @(posedge clk) begin
    if (rst) begin
      gc_byte <= 8'h00;
    end else if (gc_strobe) begin
      gc_byte <= hdlc_owns ? octet : gc_reg;
    end
  end

endmodule

// File: rtl/gchdlc_checker.sv
module gchdlc_checker #(
  parameter logic [7:0] CSR_ADDR = 8'h34
) (
  input logic       clk,
  input logic       rst,
  input logic       gc_strobe,
  input logic [7:0] gc_byte,
  input logic       irq,
  input logic       busy,
  input logic       stat,
  input logic       ie,
  input logic       route,
  input logic       reg_rd,
  input logic [7:0] reg_addr
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_gc_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(gc_strobe) |-> $stable(gc_byte));

  assert_open_flag_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    ($rose(busy) && !$past(route)) |-> (gc_byte == 8'h7E));

  assert_busy_on_slot_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($rose(busy) || $fell(busy)) |-> $past(gc_strobe));

  assert_done_sets_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(busy) |-> stat);

  assert_clear_by_read_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(stat) |-> $past(reg_rd && (reg_addr == CSR_ADDR)));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    irq == (stat && ie));

endmodule

bind gc_hdlc_repeater gchdlc_checker #(.CSR_ADDR(CSR_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .gc_strobe (gc_strobe),
  .gc_byte   (gc_byte),
  .irq       (irq),
  .busy      (seq_busy),
  .stat      (csr_stat),
  .ie        (csr_ie),
  .route     (route),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr)
);

// File: tb/gc_hdlc_repeater_test.sv
module gc_hdlc_repeater_test;

  localparam int DEPTH  = 16;
  localparam int PERIOD = 5;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [7:0] CS = 8'h34;
  localparam logic [7:0] GC = 8'h35;
  localparam logic [7:0] GCV = 8'hC3;

  // {length, pattern seed}
  localparam int NCASE = 4;
  localparam logic [15:0] CASES [NCASE] = '{
    {8'd1,  8'h11},
    {8'd4,  8'hA5},
    {8'd16, 8'h3C},
    {8'd7,  8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, msg_wr = 0, gc_strobe = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, msg_wdata = 0;
  logic [AW-1:0] msg_waddr = 0;
  logic [LW-1:0] msg_len = LW'(1);
  logic [7:0] reg_rdata, gc_byte;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gc_hdlc_repeater #(.DEPTH(DEPTH), .PERIOD_FRAMES(PERIOD)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_wr(msg_wr),
    .msg_waddr(msg_waddr), .msg_wdata(msg_wdata), .msg_len(msg_len),
    .gc_strobe(gc_strobe), .gc_byte(gc_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'((i * 37) + 11);
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic load_msg(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); msg_wr = 1; msg_waddr = AW'(i); msg_wdata = pat(seed, i);
    end
    @(negedge clk); msg_wr = 0;
  endtask

  task automatic slot();
    @(negedge clk); gc_strobe = 1;
    @(negedge clk); gc_strobe = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 gc_byte", gc_byte, 8'h00);
    chk("R1 irq", irq, 0);
    rd_reg(CS, d); chk("R1 csr", d, 8'h00);
    rd_reg(GC, d); chk("R1 gc reg", d, 8'h00);

    // R2 static GC byte while stopped
    wr_reg(GC, GCV);
    rd_reg(GC, d); chk("R2 gc readback", d, GCV);
    slot(); chk("R2 slot carries reg", gc_byte, GCV);

    // table walk: R3 R4 R5 R6 R7 R9 R10
    for (int c = 0; c < NCASE; c++) begin
      int len, p;
      logic [7:0] s0, s1;
      len = int'(CASES[c][15:8]);
      s0 = CASES[c][7:0];
      s1 = ~s0;
      p = len + 2 + PERIOD;
      msg_len = LW'(len);
      load_msg(len, s0);
      wr_reg(CS, 8'h0A);      // run=1, ie=1
      for (int k = 0; k < p + len + 3; k++) begin
        int m;
        logic [7:0] eb;
        logic eby, est;
        m = k % p;
        eby = (m <= len + 1);
        est = (m == len + 2);
        if (m >= 1 && m <= len) eb = pat((k >= p) ? s1 : s0, m - 1);
        else eb = 8'h7E;
        slot();
        chk("R3 R4 R9 slot octet", gc_byte, eb);
        chk("R7 irq", irq, est);
        rd_reg(CS, d);
        chk("R5 busy bit", d[2], eby);
        chk("R6 done bit", d[0], est);
        if (k == len + 3) load_msg(len, s1);   // R10 refresh between repeats
      end
      wr_reg(CS, 8'h02);
    end

    // R9 route switch in mid-frame
    msg_len = LW'(3);
    load_msg(3, 8'h5A);
    wr_reg(CS, 8'h0A);
    slot(); chk("R3 opening flag", gc_byte, 8'h7E);
    wr_reg(CS, 8'h1A);
    slot(); chk("R9 route to reg mid-frame", gc_byte, GCV);
    wr_reg(CS, 8'h0A);
    slot(); chk("R9 route back", gc_byte, pat(8'h5A, 1));
    wr_reg(CS, 8'h02);
    slot(); chk("R8 last octet after stop", gc_byte, pat(8'h5A, 2));
    slot(); chk("R8 closing flag after stop", gc_byte, 8'h7E);
    slot(); chk("R8 completion slot", gc_byte, 8'h7E);
    rd_reg(CS, d); chk("R8 done after stop", d, 8'h03);
    for (int k = 0; k < PERIOD + 2; k++) begin
      slot(); chk("R8 no repeat", gc_byte, GCV);
    end
    rd_reg(CS, d); chk("R8 idle csr", d, 8'h02);

    // R6 collision of read and completion, R7 with enable off
    msg_len = LW'(1);
    wr_reg(CS, 8'h08);       // run=1, ie=0
    slot(); slot(); slot();  // opening, data, closing
    @(negedge clk); gc_strobe = 1; reg_rd = 1; reg_addr = CS;
    @(negedge clk); gc_strobe = 0; reg_rd = 0; d = reg_rdata;
    chk("R6 read in completion cycle", d, 8'h0C);
    chk("R7 irq masked", irq, 0);
    wr_reg(CS, 8'h0A);
    chk("R7 irq after enable", irq, 1);
    rd_reg(CS, d); chk("R6 set wins", d[0], 1);
    chk("R7 irq after clear", irq, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule